// File: doc/BRIEF.md
# Video Settings Serial Register Slave

This block is the write-only register front end of a video processing chip. It listens on a two-wire serial bus (I2C) and stores the picture settings the chip uses: brightness, saturation, contrast, a hue voltage, three colour gains, a peak drive limit and two control bytes. The bus lines come in through two-flop synchronizers and are sampled by the system clock. The slave takes part in the bus only by pulling the data line low in acknowledge slots. It never stretches the clock and never returns data.

Each transfer carries a device address byte, a sub-address byte and one or more data bytes. In the direct mode a data byte updates its register as soon as it arrives, and the sub-address steps forward after each byte. In the buffered mode, chosen by a bit of the first control byte, only one data byte per transfer is taken. That byte waits in a shadow entry and reaches the live registers when the vertical blanking strobe is next high. Until then every acknowledge slot is left released. All sixteen registers are presented as one flat vector, and the control bits are also brought out decoded.

Top module: `vcr_reg_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0x88 (7-bit address 1000100, write). It leaves any other address byte unacknowledged and ignores the rest of that transfer.
- R2: A sub-address byte from 0x00 to 0x0F is acknowledged. A larger value is not acknowledged, and the data bytes that follow it change nothing.
- R3: With the buffered-mode bit at 0, each accepted data byte moves the sub-address on by one, and 0x0F wraps to 0x00.
- R4: The registers at 0x00–0x06 and 0x0A keep only data bits 5:0 and read 0 in bits 7:6. Registers 0x0C and 0x0D keep all eight bits.
- R5: Sub-addresses 0x07, 0x08, 0x09, 0x0B, 0x0E and 0x0F acknowledge their data, but those registers stay at 0x01.
- R6: After reset every register reads 0x01 and the data line is released.
- R7: The decoded outputs follow these bits. In register 0x0C: bit 7 two-level sandcastle, bit 5 buffered mode, bit 3 NTSC matrix. In register 0x0D: bit 4 cut-off loop off, bit 3 switch-2 disable, bit 2 switch-2 force, bit 1 switch-1 disable, bit 0 switch-1 force.
- R8: In buffered mode an accepted data byte is not visible in the registers until the vertical blanking strobe is high. It becomes visible within two clocks of that.
- R9: In buffered mode a second data byte in the same transfer is not acknowledged and is dropped. While a commit is pending, even the address byte of a new transfer is not acknowledged.
- R10: A start condition (SDA falling while SCL is high) begins a new address phase at any point, even in the middle of a transfer. Bytes clocked without a start change nothing.
- R11: The slave pulls SDA low only in the ninth clock slot of an accepted byte. It changes the pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 2 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| vblank_i | input | 1 | Vertical blanking strobe, synchronous to clk |
| regs_o | output | 128 | All 16 registers, register n in bits 8n+7:8n |
| sc_two_level_o | output | 1 | Two-level sandcastle select |
| buf_mode_o | output | 1 | Buffered update mode active |
| ntsc_matrix_o | output | 1 | NTSC matrix select |
| cutoff_off_o | output | 1 | Automatic cut-off loop disabled |
| sw2_dis_o | output | 1 | Fast switch 2 pin disable |
| sw2_on_o | output | 1 | Fast switch 2 forced on |
| sw1_dis_o | output | 1 | Fast switch 1 pin disable |
| sw1_on_o | output | 1 | Fast switch 1 forced on |

## Verification
A bad bit counter or phase state shows in the next acknowledge slot. The slot lands at the wrong clock, or the byte is left unacknowledged when it should be acknowledged, or the other way round. A bad sub-address counter puts a byte into the wrong register, and this is visible on `regs_o` about three clocks after the SCL fall that ends the byte. A stuck pending flag in the buffered mode shows up at once as unacknowledged address bytes. A commit that fires too early shows up as a register that changes before the blanking strobe.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NREG     = 16;
  localparam int DW       = 8;
  localparam int AW       = $clog2(NREG);
  localparam logic [DW-1:0] DEV_ADDR = 8'h88;
  localparam logic [DW-1:0] RST_VAL  = 8'h01;
  localparam int CTL_A    = 12;
  localparam int CTL_B    = 13;
  localparam int BUF_BIT  = 5;
  localparam int NARROW_W = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_e;

  function automatic logic is_reserved(input int a);
    return (a == 7) || (a == 8) || (a == 9) || (a == 11) || (a == 14) || (a == 15);
  endfunction

  function automatic logic is_narrow(input int a);
    return (a <= 6) || (a == 10);
  endfunction
endpackage

// File: rtl/vcr_sync.sv
module vcr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vcr_bus_fsm.sv
module vcr_bus_fsm
  import vcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          busy_i,
  input  logic          buf_mode_i,
  output logic          sda_pull_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          scl_d, sda_d;
  phase_e        ph_q, ph_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          slot_q, slot_n;
  logic          pull_q, pull_n;
  logic [AW-1:0] sub_q, sub_n;
  logic          got_q, got_n;
  logic          rise, fall, start, stop, accept, wr_en;

  assign rise  = scl_s & ~scl_d;
  assign fall  = ~scl_s & scl_d;
  assign start = scl_s & scl_d & sda_d & ~sda_s;
  assign stop  = scl_s & scl_d & ~sda_d & sda_s;

  always_comb begin
    unique case (ph_q)
      PH_ADDR: accept = (sh_q == DEV_ADDR) && !busy_i;
      PH_SUB:  accept = (sh_q[DW-1:AW] == '0) && !busy_i;
      PH_DATA: accept = !busy_i && !(buf_mode_i && got_q);
      default: accept = 1'b0;
    endcase
  end

  always_comb begin
    ph_n = ph_q; cnt_n = cnt_q; sh_n = sh_q; slot_n = slot_q;
    pull_n = pull_q; sub_n = sub_q; got_n = got_q; wr_en = 1'b0;
    if (start) begin
      ph_n = PH_ADDR; cnt_n = '0; slot_n = 1'b0; pull_n = 1'b0; got_n = 1'b0;
    end else if (stop) begin
      ph_n = PH_IDLE; cnt_n = '0; slot_n = 1'b0; pull_n = 1'b0;
    end else if (ph_q != PH_IDLE) begin
      if (rise && !slot_q) begin
        sh_n  = {sh_q[DW-2:0], sda_s};
        cnt_n = cnt_q + 4'd1;
      end
      if (fall) begin
        if (slot_q) begin
          slot_n = 1'b0; pull_n = 1'b0; cnt_n = '0;
          if (!pull_q) ph_n = PH_IDLE;
        end else if (cnt_q == 4'(DW)) begin
          slot_n = 1'b1;
          pull_n = accept;
          if (accept) begin
            unique case (ph_q)
              PH_ADDR: ph_n = PH_SUB;
              PH_SUB: begin
                ph_n  = PH_DATA;
                sub_n = sh_q[AW-1:0];
              end
              default: begin
                wr_en = 1'b1;
                got_n = 1'b1;
                if (!buf_mode_i) sub_n = sub_q + 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1; ph_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0;
      slot_q <= 1'b0; pull_q <= 1'b0; sub_q <= '0; got_q <= 1'b0;
    end else begin
      scl_d <= scl_s; sda_d <= sda_s; ph_q <= ph_n; cnt_q <= cnt_n; sh_q <= sh_n;
      slot_q <= slot_n; pull_q <= pull_n; sub_q <= sub_n; got_q <= got_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = wr_en;
  assign wr_addr_o  = sub_q;
  assign wr_data_o  = sh_q;

  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q != $past(pull_q)) |-> !scl_s)
    else $error("pull changed while SCL high");

  p_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pull_q)
    else $error("write without acknowledge");
endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile
  import vcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             vblank_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic             pend_o,
  output logic             buf_mode_o
);
  logic [DW-1:0] act_q [NREG];
  logic [DW-1:0] sh_data_q;
  logic [AW-1:0] sh_addr_q;
  logic          pend_q, pend_n, commit, direct, buf_mode;

  assign buf_mode = act_q[CTL_A][BUF_BIT];
  assign commit   = pend_q & vblank_i;
  assign direct   = wr_en_i & ~buf_mode;

  always_comb begin
    pend_n = pend_q;
    if (commit) pend_n = 1'b0;
    else if (wr_en_i && buf_mode) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; sh_data_q <= '0; sh_addr_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (wr_en_i && buf_mode) begin
        sh_data_q <= wr_data_i;
        sh_addr_q <= wr_addr_i;
      end
    end
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (is_reserved(i)) begin : g_rsvd
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) act_q[i] <= RST_VAL;
          else act_q[i] <= RST_VAL;
        end
      end else begin : g_live
        logic          ld;
        logic [DW-1:0] src, val;
        assign ld  = (direct && wr_addr_i == AW'(i)) || (commit && sh_addr_q == AW'(i));
        assign src = direct ? wr_data_i : sh_data_q;
        if (is_narrow(i)) begin : g_nar
          assign val = {{(DW-NARROW_W){1'b0}}, src[NARROW_W-1:0]};
        end else begin : g_wide
          assign val = src;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) act_q[i] <= RST_VAL;
          else if (ld) act_q[i] <= val;
        end
      end
      assign regs_o[i*DW +: DW] = act_q[i];
    end
  endgenerate

  assign pend_o     = pend_q;
  assign buf_mode_o = buf_mode;

  p_commit_in_vblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(vblank_i))
    else $error("commit outside blanking");

  p_hold_outside_vblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(buf_mode) && !$past(vblank_i)) |-> $stable(regs_o))
    else $error("buffered register changed outside blanking");
endmodule

// File: rtl/vcr_reg_slave.sv
module vcr_reg_slave
  import vcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               vblank_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic               sc_two_level_o,
  output logic               buf_mode_o,
  output logic               ntsc_matrix_o,
  output logic               cutoff_off_o,
  output logic               sw2_dis_o,
  output logic               sw2_on_o,
  output logic               sw1_dis_o,
  output logic               sw1_on_o
);
  logic [1:0]    lines_s;
  logic          wr_en, pend, buf_mode;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] ctl_a, ctl_b;

  vcr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s));

  vcr_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .busy_i(pend), .buf_mode_i(buf_mode), .sda_pull_o(sda_pull_o),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  vcr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .vblank_i(vblank_i), .regs_o(regs_o),
    .pend_o(pend), .buf_mode_o(buf_mode));

  assign ctl_a          = regs_o[CTL_A*DW +: DW];
  assign ctl_b          = regs_o[CTL_B*DW +: DW];
  assign sc_two_level_o = ctl_a[7];
  assign buf_mode_o     = buf_mode;
  assign ntsc_matrix_o  = ctl_a[3];
  assign cutoff_off_o   = ctl_b[4];
  assign sw2_dis_o      = ctl_b[3];
  assign sw2_on_o       = ctl_b[2];
  assign sw1_dis_o      = ctl_b[1];
  assign sw1_on_o       = ctl_b[0];

  p_no_write_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !pend)
    else $error("write accepted while commit pending");
endmodule

// File: tb/vcr_reg_slave_bench.sv
module vcr_reg_slave_bench;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, vblank = 1'b0;
  logic sda_pull;
  logic [127:0] regs;
  logic sc2, bufm, ntsc, coff, s2d, s2o, s1d, s1o;
  wire  sda_line = sda_m & ~sda_pull;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] exp_r [16];
  logic  exp_q [$];
  string tag_q [$];
  event  ack_ev;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  vcr_reg_slave u_vcr_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .vblank_i(vblank), .regs_o(regs), .sc_two_level_o(sc2), .buf_mode_o(bufm),
    .ntsc_matrix_o(ntsc), .cutoff_off_o(coff), .sw2_dis_o(s2d), .sw2_on_o(s2o),
    .sw1_dis_o(s1d), .sw1_on_o(s1o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < 16; i++) check(tag, {24'h0, regs[i*8 +: 8]}, {24'h0, exp_r[i]});
  endtask

  // monitor: pops expected acknowledge values as slots arrive
  initial begin
    forever begin
      @(ack_ev);
      if (exp_q.size() == 0) check("R11 unexpected slot", 1, 0);
      else check(tag_q.pop_front(), {31'h0, sda_pull}, {31'h0, exp_q.pop_front()});
    end
  end

  task automatic start_c();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send(input logic [7:0] b, input logic ack, input string tag);
    exp_q.push_back(ack); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q); scl_m = 1'b1; wclk(Q);
      if (i == 7) check("R11 line free in data bit", {31'h0, sda_pull}, 0);
      wclk(Q); scl_m = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q); -> ack_ev; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic blank();
    vblank = 1'b1; wclk(4); vblank = 1'b0; wclk(2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_r[i] = 8'h01;
    wclk(5); rst_n = 1'b1; wclk(5);
    chk_all("R6 reset value");
    check("R6 line released", {31'h0, sda_pull}, 0);
    check("R7 reset decode", {24'h0, sc2, bufm, ntsc, coff, s2d, s2o, s1d, s1o}, 32'h01);

    // R4 direct writes with masking
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h00, 1, "R2 sub");
    send(8'hFF, 1, "R4 data"); send(8'h23, 1, "R3 data"); stop_c();
    exp_r[0] = 8'h3F; exp_r[1] = 8'h23; wclk(4); chk_all("R4 narrow mask");

    // R7 control bytes
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h0C, 1, "R2 sub");
    send(8'h88, 1, "R7 data"); send(8'h1F, 1, "R7 data"); stop_c();
    exp_r[12] = 8'h88; exp_r[13] = 8'h1F; wclk(4); chk_all("R4 wide regs");
    check("R7 decode", {24'h0, sc2, bufm, ntsc, coff, s2d, s2o, s1d, s1o}, 32'hBF);

    // R3 wrap, R5 reserved
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h0E, 1, "R2 sub");
    send(8'h55, 1, "R5 rsvd ack"); send(8'h66, 1, "R5 rsvd ack");
    send(8'h77, 1, "R3 wrapped data"); stop_c();
    exp_r[0] = 8'h37; wclk(4); chk_all("R3 wrap R5 reserved");

    // R1 wrong addresses
    start_c(); send(8'h8A, 0, "R1 wrong addr"); send(8'h01, 0, "R1 ignored");
    send(8'h11, 0, "R1 ignored"); stop_c();
    start_c(); send(8'h89, 0, "R1 read addr"); stop_c();
    wclk(4); chk_all("R1 no change");

    // R2 sub-address out of range
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h10, 0, "R2 bad sub");
    send(8'h2A, 0, "R2 ignored"); stop_c();
    wclk(4); chk_all("R2 no change");

    // R4 peak limit, R5 reserved 0x0B
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h0A, 1, "R2 sub");
    send(8'hC5, 1, "R4 data"); send(8'h99, 1, "R5 rsvd ack"); stop_c();
    exp_r[10] = 8'h05; wclk(4); chk_all("R4 R5 peak and reserved");

    // enter buffered mode (direct write)
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h0C, 1, "R2 sub");
    send(8'h20, 1, "R7 data"); stop_c();
    exp_r[12] = 8'h20; wclk(4);
    check("R7 buffered bit", {31'h0, bufm}, 1);

    // R8 R9 buffered behaviour
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h02, 1, "R2 sub");
    send(8'h11, 1, "R8 data"); send(8'h22, 0, "R9 second byte"); stop_c();
    wclk(4); chk_all("R8 held before blanking");
    start_c(); send(8'h88, 0, "R9 busy addr"); stop_c();
    blank(); exp_r[2] = 8'h11; chk_all("R8 committed");

    start_c(); send(8'h88, 1, "R9 accepted after commit"); send(8'h0C, 1, "R2 sub");
    send(8'h00, 1, "R8 data"); stop_c();
    wclk(4); check("R8 mode bit held", {31'h0, bufm}, 1);
    blank(); exp_r[12] = 8'h00; check("R8 mode bit committed", {31'h0, bufm}, 0);

    // R10 repeated start and bytes without start
    start_c(); send(8'h88, 1, "R1 addr"); send(8'h03, 1, "R2 sub");
    start_c(); send(8'h88, 1, "R10 restart addr"); send(8'h04, 1, "R2 sub");
    send(8'h2A, 1, "R10 data"); stop_c();
    exp_r[4] = 8'h2A; wclk(4); chk_all("R10 restart");
    send(8'h88, 0, "R10 no start"); send(8'h05, 0, "R10 no start");
    send(8'h3C, 0, "R10 no start"); stop_c();
    wclk(4); chk_all("R10 ignored without start");

    wclk(10);
    check("R11 all slots seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule